// File: doc/BRIEF.md
# Programmable Raster Timing Generator with Borders

This block produces the horizontal and vertical timing of a display raster. A pixel counter runs across each line and a line counter advances once each time the pixel counter wraps. Each axis is split by programmed positions into six regions: sync, back porch, leading border, active display, trailing border and front porch. From the two counters the block derives hsync and vsync with a selectable polarity per axis, a flag for the border area around the picture, a flag for the active picture, and the current pixel and line positions.

Software programs the block through a simple write port. There are six timing registers, three per axis, and one control register. The control register enables the generator, can hold it stopped, and picks the sync polarities. New timing values are taken into a shadow copy only at the end of a frame, so a frame is never drawn with a mix of old and new values. While the generator is stopped, the shadow copy follows the programmed values directly.

Top module: `raster_timing_gen`

## Requirements
- R1: A write (wr_en high at a rising clock edge) to wr_addr 0 to 5 stores only bits 11:0 and bits 27:16 of wr_data in that timing register. All other bits of the word have no effect. A write to wr_addr 6 updates the control register. A write to wr_addr 7 is ignored.
- R2: The timing registers are laid out as low field (bits 11:0) / high field (bits 27:16). Address 0 holds the line total / sync end (back porch start). Address 1 holds the left border start / display start. Address 2 holds the right border start / front porch start. Addresses 3, 4 and 5 use the same layout for the vertical axis, counted in lines.
- R3: Control bit 31 enables the generator. Bit 0 and bit 2 are stop bits. The generator runs only when bit 31 is set and both stop bits are clear. In the cycle after any edge at which it is not running, pix_x and line_y are 0.
- R4: While running, pix_x counts 0 up to the line total minus 1 and then wraps to 0. line_y steps once at each pixel wrap and wraps to 0 after the frame total of lines. After the generator is enabled again, counting restarts from position 0.
- R5: hsync is active while running and pix_x is below the sync end. vsync is active while running and line_y is below the vertical sync end. When not running, both syncs sit at their inactive level.
- R6: border_active is high while running when both positions lie inside their axis' bordered span (from the leading border start up to the front porch start) and at least one position is inside a border window of its axis: from the leading border start to the display start, or from the trailing border start to the front porch start.
- R7: display_active is high while running only when each position lies from its axis' display start up to, but not including, its trailing border start.
- R8: Timing values written while the generator runs take effect only at the edge where both counters wrap together. The frame in progress completes with the old values.
- R9: Control bit 1 selects the hsync polarity and bit 3 selects the vsync polarity (1 = active high, 0 = active low). A change of polarity shows on the sync outputs in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register index (0-5 timing, 6 control) |
| wr_data | input | 32 | Register write data |
| hsync | output | 1 | Horizontal sync, polarity per control bit 1 |
| vsync | output | 1 | Vertical sync, polarity per control bit 3 |
| border_active | output | 1 | Position lies in a border region |
| display_active | output | 1 | Position lies in the active picture |
| pix_x | output | 12 | Current pixel position in the line |
| line_y | output | 12 | Current line position in the frame |

## Verification
The bench uses the default 12-bit field width. It programs very small rasters: a 20-pixel by 12-line frame, and later 16-pixel lines. With these sizes every region boundary, many line and frame wraps, and a reprogramming in the middle of a frame all occur within a few thousand cycles. A behavioural model built from integers predicts every output on every clock. Directed measurements of line length, region widths, stop and restart, and polarity changes are added on top of that comparison.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

  localparam int POS_W    = 12;
  localparam int WORD_W   = 32;
  localparam int ADDR_W   = 3;
  localparam int LO_FIELD = 0;
  localparam int HI_FIELD = 16;
  localparam int NUM_TREG = 6;
  localparam int CTRL_IDX = 6;
  localparam int NUM_AXIS = 2;

  localparam int CTL_EN_BIT     = 31;
  localparam int CTL_STOPH_BIT  = 0;
  localparam int CTL_POLH_BIT   = 1;
  localparam int CTL_STOPV_BIT  = 2;
  localparam int CTL_POLV_BIT   = 3;

  localparam logic [WORD_W-1:0] FIELD_MASK =
    (WORD_W'((1 << POS_W) - 1) << LO_FIELD) | (WORD_W'((1 << POS_W) - 1) << HI_FIELD);

  typedef logic [POS_W-1:0] pos_t;

  typedef struct packed {
    pos_t total;
    pos_t sync_end;
    pos_t lead_start;
    pos_t disp_start;
    pos_t trail_start;
    pos_t porch_start;
  } axis_tim_t;

  typedef struct packed {
    logic enable;
    logic stop_v;
    logic pol_v;
    logic stop_h;
    logic pol_h;
  } ctl_t;

  function automatic axis_tim_t unpack_axis(input logic [WORD_W-1:0] r_tot,
                                            input logic [WORD_W-1:0] r_lead,
                                            input logic [WORD_W-1:0] r_trail);
    axis_tim_t t;
    t.total       = r_tot[LO_FIELD +: POS_W];
    t.sync_end    = r_tot[HI_FIELD +: POS_W];
    t.lead_start  = r_lead[LO_FIELD +: POS_W];
    t.disp_start  = r_lead[HI_FIELD +: POS_W];
    t.trail_start = r_trail[LO_FIELD +: POS_W];
    t.porch_start = r_trail[HI_FIELD +: POS_W];
    return t;
  endfunction

  // True when the position is the last one before the total (totals 0 and 1 wrap every step).
  function automatic logic is_last(input pos_t p, input pos_t total);
    return ({1'b0, p} + 1'b1) >= {1'b0, total};
  endfunction

  function automatic logic in_span(input pos_t p, input pos_t lo, input pos_t hi);
    return (p >= lo) && (p < hi);
  endfunction

endpackage

// File: rtl/vtg_regs.sv
module vtg_regs
  import vtg_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [WORD_W-1:0]             wr_data,
  output logic [NUM_TREG-1:0][WORD_W-1:0] treg,
  output ctl_t                          ctl
);

  genvar gi;
  generate
    for (gi = 0; gi < NUM_TREG; gi++) begin : g_treg
      logic hit;
      assign hit = wr_en && (wr_addr == ADDR_W'(gi));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   treg[gi] <= '0;
        else if (hit) treg[gi] <= wr_data & FIELD_MASK;
      end
    end
  endgenerate

  logic ctl_hit;
  assign ctl_hit = wr_en && (wr_addr == ADDR_W'(CTRL_IDX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl <= '0;
    else if (ctl_hit) begin
      ctl.enable <= wr_data[CTL_EN_BIT];
      ctl.stop_v <= wr_data[CTL_STOPV_BIT];
      ctl.pol_v  <= wr_data[CTL_POLV_BIT];
      ctl.stop_h <= wr_data[CTL_STOPH_BIT];
      ctl.pol_h  <= wr_data[CTL_POLH_BIT];
    end
  end

  // R1: stored timing words never carry bits outside the two fields
  assert_field_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(0)) |=> ((treg[0] & ~FIELD_MASK) == '0));

  // R1: a write to another index leaves timing register 0 untouched
  assert_other_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != ADDR_W'(0)) |=> $stable(treg[0]));

endmodule

// File: rtl/vtg_axis_counter.sv
module vtg_axis_counter
  import vtg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic step,
  input  pos_t total,
  output pos_t cnt,
  output logic wrap
);

  pos_t cnt_q;

  assign wrap = run && step && is_last(cnt_q, total);
  assign cnt  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (!run)  cnt_q <= '0;
    else if (wrap)  cnt_q <= '0;
    else if (step)  cnt_q <= cnt_q + 1'b1;
  end

  assert_hold_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));

  assert_step_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && step && !wrap) |=> (cnt == $past(cnt) + 1'b1));

  assert_wrap_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0));

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !step) |=> $stable(cnt));

endmodule

// File: rtl/vtg_axis_decode.sv
module vtg_axis_decode
  import vtg_pkg::*;
(
  input  pos_t      pos,
  input  axis_tim_t tim,
  output logic      in_sync,
  output logic      in_frame,
  output logic      in_disp,
  output logic      in_bwin
);

  logic lead_win, trail_win;

  always_comb begin
    in_sync   = pos < tim.sync_end;
    in_frame  = in_span(pos, tim.lead_start, tim.porch_start);
    in_disp   = in_span(pos, tim.disp_start, tim.trail_start);
    lead_win  = in_span(pos, tim.lead_start, tim.disp_start);
    trail_win = in_span(pos, tim.trail_start, tim.porch_start);
    in_bwin   = lead_win || trail_win;
  end

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import vtg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  output logic              hsync,
  output logic              vsync,
  output logic              border_active,
  output logic              display_active,
  output logic [POS_W-1:0]  pix_x,
  output logic [POS_W-1:0]  line_y
);

  logic [NUM_TREG-1:0][WORD_W-1:0] treg;
  ctl_t ctl;

  vtg_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .treg    (treg),
    .ctl     (ctl)
  );

  // Internal events brought out as named wires
  logic run;
  logic frame_end;
  logic load_shadow;

  assign run = ctl.enable && !ctl.stop_h && !ctl.stop_v;

  axis_tim_t live_tim [NUM_AXIS];
  axis_tim_t sh_tim   [NUM_AXIS];
  pos_t      pos      [NUM_AXIS];
  logic      step     [NUM_AXIS];
  logic      wrap     [NUM_AXIS];
  logic      a_sync   [NUM_AXIS];
  logic      a_frame  [NUM_AXIS];
  logic      a_disp   [NUM_AXIS];
  logic      a_bwin   [NUM_AXIS];

  assign step[0] = run;
  assign step[1] = wrap[0];

  genvar ax;
  generate
    for (ax = 0; ax < NUM_AXIS; ax++) begin : g_axis
      assign live_tim[ax] = unpack_axis(treg[3*ax], treg[3*ax+1], treg[3*ax+2]);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           sh_tim[ax] <= '0;
        else if (load_shadow) sh_tim[ax] <= live_tim[ax];
      end

      vtg_axis_counter u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .step  (step[ax]),
        .total (sh_tim[ax].total),
        .cnt   (pos[ax]),
        .wrap  (wrap[ax])
      );

      vtg_axis_decode u_dec (
        .pos      (pos[ax]),
        .tim      (sh_tim[ax]),
        .in_sync  (a_sync[ax]),
        .in_frame (a_frame[ax]),
        .in_disp  (a_disp[ax]),
        .in_bwin  (a_bwin[ax])
      );
    end
  endgenerate

  assign frame_end   = wrap[0] && wrap[1];
  assign load_shadow = !run || frame_end;

  logic h_on, v_on;
  assign h_on = run && a_sync[0];
  assign v_on = run && a_sync[1];

  assign hsync          = ctl.pol_h ? h_on : !h_on;
  assign vsync          = ctl.pol_v ? v_on : !v_on;
  assign display_active = run && a_disp[0] && a_disp[1];
  assign border_active  = run && a_frame[0] && a_frame[1] && (a_bwin[0] || a_bwin[1]);
  assign pix_x          = pos[0];
  assign line_y         = pos[1];

  // R8: the shadow timing stays put mid-frame while running
  assert_shadow_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !frame_end) |=> ($stable(sh_tim[0]) && $stable(sh_tim[1])));

  // R6/R7: a pixel is never border and picture at once
  assert_region_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(display_active && border_active));

  // R7: no picture or border while not running
  assert_quiet_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!display_active && !border_active));

  // R5: an active hsync level implies the sync window
  assert_hsync_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hsync == ctl.pol_h) |-> (run && pix_x < sh_tim[0].sync_end));

  // R5: an active vsync level implies the sync window
  assert_vsync_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync == ctl.pol_v) |-> (run && line_y < sh_tim[1].sync_end));

  // R4: the line counter only moves on a pixel wrap
  assert_line_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap[0]) |=> $stable(line_y));

endmodule

// File: tb/sim_raster_timing_gen.sv
`timescale 1ns/1ps
module sim_raster_timing_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        hsync, vsync, border_active, display_active;
  logic [11:0] pix_x, line_y;

  always #2 clk = ~clk;

  raster_timing_gen u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hsync(hsync), .vsync(vsync), .border_active(border_active),
    .display_active(display_active), .pix_x(pix_x), .line_y(line_y)
  );

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  // Behavioural reference model
  int unsigned m_live [6];
  int unsigned m_sh   [6];
  int unsigned m_ctl;
  int m_h, m_v;

  function automatic int lo(input int unsigned w); return int'(w & 32'hFFF); endfunction
  function automatic int hi(input int unsigned w); return int'((w >> 16) & 32'hFFF); endfunction
  function automatic bit m_run();
    return m_ctl[31] && !m_ctl[0] && !m_ctl[2];
  endfunction
  function automatic bit span(input int p, input int a, input int b);
    return (p >= a) && (p < b);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_live[i]) begin m_live[i] = 0; m_sh[i] = 0; end
      m_ctl = 0; m_h = 0; m_v = 0;
    end else begin
      if (!m_run()) begin
        m_h = 0; m_v = 0; m_sh = m_live;
      end else begin
        bit hw, vw;
        hw = (m_h + 1) >= lo(m_sh[0]);
        vw = hw && ((m_v + 1) >= lo(m_sh[3]));
        if (hw && vw) m_sh = m_live;
        if (hw) begin
          m_h = 0;
          m_v = vw ? 0 : m_v + 1;
        end else m_h = m_h + 1;
      end
      if (wr_en) begin
        if (wr_addr < 6) m_live[wr_addr] = wr_data & 32'h0FFF0FFF;
        else if (wr_addr == 6) m_ctl = wr_data;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit r, hs, vs, disp, bord;
      r    = m_run();
      hs   = r && (m_h < hi(m_sh[0]));
      vs   = r && (m_v < hi(m_sh[3]));
      disp = r && span(m_h, hi(m_sh[1]), lo(m_sh[2])) && span(m_v, hi(m_sh[4]), lo(m_sh[5]));
      bord = r && span(m_h, lo(m_sh[1]), hi(m_sh[2])) && span(m_v, lo(m_sh[4]), hi(m_sh[5]))
               && (span(m_h, lo(m_sh[1]), hi(m_sh[1])) || span(m_h, lo(m_sh[2]), hi(m_sh[2]))
                || span(m_v, lo(m_sh[4]), hi(m_sh[4])) || span(m_v, lo(m_sh[5]), hi(m_sh[5])));
      chk("R4 pix_x", int'(pix_x), m_h);
      chk("R4 line_y", int'(line_y), m_v);
      chk("R5 hsync", int'(hsync), int'(m_ctl[1] ? hs : !hs));
      chk("R5 vsync", int'(vsync), int'(m_ctl[3] ? vs : !vs));
      chk("R6 border_active", int'(border_active), int'(bord));
      chk("R7 display_active", int'(display_active), int'(disp));
    end
  end

  task automatic summary();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected<=150000", cyc);
      summary();
    end
  end

  task automatic wr(input int a, input int unsigned d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic line_len(output int n);
    while (pix_x != 0) @(negedge clk);
    n = 0;
    do begin @(negedge clk); n++; end while (pix_x != 0);
  endtask

  initial begin
    int n, dcnt, bcnt, mx;
    idle(4);
    rst_n = 1'b1;
    @(negedge clk);
    // R3: reset state, generator disabled
    chk("R3 reset pix_x", int'(pix_x), 0);
    chk("R3 reset line_y", int'(line_y), 0);
    chk("R3 reset display", int'(display_active), 0);

    // Mode A with junk in bits outside the fields (R1)
    wr(0, 32'hF002F014);   // total 20, sync end 2
    wr(1, 32'h3006B004);   // left border 4, display 6
    wr(2, 32'hC010F00E);   // right border 14, porch 16
    wr(3, 32'h5001A00C);   // 12 lines, vsync end 1
    wr(4, 32'h00030002);   // top border 2, display 3
    wr(5, 32'h000A0009);   // bottom border 9, porch 10
    wr(7, 32'hFFFFFFFF);   // R1: unmapped index

    // R3: enabled but horizontal stop set
    wr(6, 32'h8000000B);
    idle(30);
    chk("R3 stopped pix_x", int'(pix_x), 0);
    chk("R3 stopped line_y", int'(line_y), 0);
    chk("R3 stopped hsync idle", int'(hsync), 0);

    wr(6, 32'h8000000A);
    idle(500);
    line_len(n);
    chk("R1 line length ignores junk bits", n, 20);

    // R2: one display line has 8 picture and 4 border pixels
    while (!(line_y == 5 && pix_x == 0)) @(negedge clk);
    dcnt = 0; bcnt = 0;
    for (int i = 0; i < 20; i++) begin
      dcnt += int'(display_active); bcnt += int'(border_active);
      @(negedge clk);
    end
    chk("R2 picture width", dcnt, 8);
    chk("R2 border width", bcnt, 4);

    // R9: polarity flip to active-low on both axes
    wr(6, 32'h80000000);
    for (int i = 0; i < 25; i++) begin
      chk("R9 hsync low-active", int'(hsync), (pix_x < 2) ? 0 : 1);
      chk("R9 vsync low-active", int'(vsync), (line_y < 1) ? 0 : 1);
      @(negedge clk);
    end
    wr(6, 32'h8000000A);

    // R8: reprogram the horizontal axis mid-frame
    while (!(line_y == 3 && pix_x == 0)) @(negedge clk);
    wr(0, 32'h00030010);
    wr(1, 32'h00050004);
    wr(2, 32'h000C000B);
    mx = 0;
    while (!(line_y == 0 && pix_x == 0)) begin
      if (int'(pix_x) > mx) mx = int'(pix_x);
      @(negedge clk);
    end
    chk("R8 old total kept to frame end", mx, 19);
    line_len(n);
    chk("R8 new total after frame end", n, 16);
    idle(300);

    // R3: vertical stop, then full disable
    wr(6, 32'h8000000E);
    idle(3);
    chk("R3 vstop pix_x", int'(pix_x), 0);
    chk("R3 vstop line_y", int'(line_y), 0);
    chk("R3 vstop vsync idle", int'(vsync), 0);
    wr(6, 32'h0000000A);
    idle(5);
    chk("R3 disabled pix_x", int'(pix_x), 0);

    // R4: restart from position 0
    wr(6, 32'h8000000A);
    chk("R4 restart pix0", int'(pix_x), 0);
    @(negedge clk);
    chk("R4 restart pix1", int'(pix_x), 1);
    chk("R4 restart line0", int'(line_y), 0);
    idle(400);
    summary();
  end

endmodule